// File: doc/BRIEF.md
# AGC Level Detector with Logarithmic Mapping

This block measures the strength of a sampled signal for an automatic gain control loop and reports it in decibels. Every clock it takes the ten most significant bits of a 14-bit two's-complement sample, rectifies them, and smooths the rectified stream with a two-stage integrate-and-dump (cascaded integrator-comb) decimator. The decimation factor is eight, so the decimator yields one 9-bit unsigned level every eight clocks. Its gain is normalised so that a steady input of magnitude `a` settles to a level of exactly `a`.

Each 9-bit level is turned into a compact floating-point code: a 3-bit exponent that marks the leading one and two mantissa bits that follow it. That 5-bit code indexes a 32-entry table that software fills with a logarithmic curve. Because the codes are spaced nearly evenly on a log axis, the entries cover the range at an even spacing in dB. The table word read out is the detected level in dB. It is presented together with a one-clock valid pulse. The table is loaded through a synchronous write port.

Top module: `agc_level_log`

## Requirements
- R1: While reset is asserted and right after it is released, `levelValid` is 0, `levelFix` is 0 and `levelDb` is 0. Every table entry resets to 0.
- R2: The detector input is `sampleIn[13:4]`, read as a signed 10-bit value. Bits `sampleIn[3:0]` have no effect on any output.
- R3: The rectifier outputs the magnitude of the 10-bit value. The most negative input (-512) gives 511.
- R4: `levelValid` is a single-cycle pulse. The first pulse follows the 9th rising edge after reset release, and each later pulse follows eight edges after the one before it.
- R5: Number the edges from 1 after reset release, and let a(j) be the rectified input sampled at edge j (0 for j < 1). With the pulse after edge V, `levelFix` = floor(sum over k=1..15 of w(k)*a(V-3-k) / 64), where w(k) = 8-|k-8|. A constant input of magnitude a therefore settles to a.
- R6: The table address is {exponent, mantissa}, with the exponent in bits [4:2] and the mantissa in bits [1:0]. For a level L < 4 the address is L. Otherwise, with p the position of the leading one of L (2..8), the exponent is p-1 and the mantissa is L[p-1:p-2].
- R7: A write with `tblWrEn` high stores `tblWrData` at `tblWrAddr` on the rising edge. With each pulse, `levelDb` carries the entry that was at the address of the current `levelFix` before the edge that raised `levelValid`. That is one clock after the level was updated.
- R8: `levelFix` changes only on the edge one clock before a pulse. `levelDb` changes only on an edge that raises `levelValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 14 | Two's-complement input sample, one per clock |
| tblWrEn | input | 1 | Table write enable |
| tblWrAddr | input | 5 | Table write address |
| tblWrData | input | 8 | Table write data |
| levelFix | output | 9 | Decimated 9-bit detected level |
| levelDb | output | 8 | Table output: detected level in dB |
| levelValid | output | 1 | One-cycle pulse marking a new level |

## Verification
Steady inputs of several magnitudes check the gain normalisation, the sign handling and the saturation of -512. Each settled level lands in a known exponent range of the address code. Random noise in the four discarded low bits, with fixed upper bits, shows whether those bits leak into the result. Random samples at several amplitude scales exercise the triangular weighting and its alignment to the decimation phase: a one-clock skew or a wrong weight changes the level. A table rewrite in the middle of the run tests the registered lookup and the write timing against a model of the table in the bench.

// File: rtl/agcdet_pkg.sv
package agcdet_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic decim;   // integrators are sampled by the combs on this edge
    logic lookup;  // table is read on this edge
  } agcStrobes_t;

endpackage

// File: rtl/agcdet_ctrl.sv
module agcdet_ctrl
  import agcdet_pkg::*;
#(
  parameter int DECIM = 8
) (
  input  logic        clk,
  input  logic        rstN,
  output agcStrobes_t strobes,
  output logic        validOut
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);

  logic [PH_W-1:0] phase;
  logic            lookupQ;
  logic            validQ;
  logic            decimNow;

  assign decimNow = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      lookupQ <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      phase   <= decimNow ? '0 : phase + 1'b1;
      lookupQ <= decimNow;
      validQ  <= lookupQ;
    end
  end

  assign strobes.decim  = decimNow;
  assign strobes.lookup = lookupQ;
  assign validOut       = validQ;
endmodule

// File: rtl/agcdet_fix2flt.sv
module agcdet_fix2flt #(
  parameter int LVL_W  = 9,
  parameter int MANT_W = 2,
  parameter int EXP_W  = 3
) (
  input  logic [LVL_W-1:0]        level,
  output logic [EXP_W+MANT_W-1:0] code
);
  localparam int POS_W = $clog2(LVL_W);

  logic [POS_W-1:0]  lead;
  logic              found;
  logic [EXP_W-1:0]  expo;
  logic [MANT_W-1:0] mant;
  logic [LVL_W-1:0]  shifted;

  // Leading-one search, scanning from the LSB so the highest set bit wins
  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = 0; i < LVL_W; i++) begin
      if (level[i]) begin
        lead  = POS_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    shifted = '0;
    if (!found || (int'(lead) < MANT_W)) begin
      expo = '0;
      mant = level[MANT_W-1:0];
    end else begin
      expo    = EXP_W'(int'(lead) - MANT_W + 1);
      shifted = level >> (int'(lead) - MANT_W);
      mant    = shifted[MANT_W-1:0];
    end
  end

  assign code = {expo, mant};
endmodule

// File: rtl/agcdet_datapath.sv
module agcdet_datapath
  import agcdet_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int DET_W  = 10,
  parameter int DECIM  = 8,
  parameter int STAGES = 2,
  parameter int MANT_W = 2,
  parameter int DB_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  agcStrobes_t         strobes,
  input  logic [IN_W-1:0]     sampleIn,
  input  logic                tblWrEn,
  input  logic [$clog2(DET_W-1+MANT_W+2)+MANT_W-1:0] tblWrAddr,
  input  logic [DB_W-1:0]     tblWrData,
  output logic [DET_W-2:0]    levelFix,
  output logic [DB_W-1:0]     levelDb
);
  localparam int ABS_W     = DET_W - 1;
  localparam int LVL_W     = ABS_W;
  localparam int GROWTH    = STAGES * $clog2(DECIM);
  localparam int ACC_W     = ABS_W + GROWTH;
  localparam int EXP_W     = $clog2(LVL_W - MANT_W + 1);
  localparam int ADDR_W    = EXP_W + MANT_W;
  localparam int TBL_DEPTH = 1 << ADDR_W;

  // Rectifier with saturation of the most negative code
  logic signed [DET_W-1:0] detIn;
  logic [DET_W-1:0]        negMag;
  logic [ABS_W-1:0]        absNext;
  logic [ABS_W-1:0]        absReg;

  assign detIn  = sampleIn[IN_W-1 -: DET_W];
  assign negMag = DET_W'(-detIn);

  always_comb begin
    if (detIn == {1'b1, {(DET_W-1){1'b0}}})
      absNext = {ABS_W{1'b1}};
    else if (detIn[DET_W-1])
      absNext = negMag[ABS_W-1:0];
    else
      absNext = detIn[ABS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) absReg <= '0;
    else       absReg <= absNext;
  end

  // Integrator chain, wrapping modulo 2^ACC_W
  logic [ACC_W-1:0] intReg [STAGES];
  logic [ACC_W-1:0] intFeed [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_integ
    if (s == 0) begin : g_first
      assign intFeed[s] = ACC_W'(absReg);
    end else begin : g_next
      assign intFeed[s] = intReg[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) intReg[s] <= '0;
      else       intReg[s] <= intReg[s] + intFeed[s];
    end
  end

  // Comb chain, evaluated on the decimation strobe
  logic [ACC_W-1:0] combIn  [STAGES];
  logic [ACC_W-1:0] combOut [STAGES];
  logic [ACC_W-1:0] combDly [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_comb
    if (s == 0) begin : g_first
      assign combIn[s] = intReg[STAGES-1];
    end else begin : g_next
      assign combIn[s] = combOut[s-1];
    end
    assign combOut[s] = combIn[s] - combDly[s];
    always_ff @(posedge clk) begin
      if (!rstN)              combDly[s] <= '0;
      else if (strobes.decim) combDly[s] <= combIn[s];
    end
  end

  logic [LVL_W-1:0] levelQ;
  always_ff @(posedge clk) begin
    if (!rstN)              levelQ <= '0;
    else if (strobes.decim) levelQ <= combOut[STAGES-1][ACC_W-1 -: LVL_W];
  end

  // Float code for the table
  logic [ADDR_W-1:0] rdAddr;
  agcdet_fix2flt #(
    .LVL_W (LVL_W),
    .MANT_W(MANT_W),
    .EXP_W (EXP_W)
  ) i_fix2flt (
    .level(levelQ),
    .code (rdAddr)
  );

  // Programmable log table, registered read
  logic [DB_W-1:0] tbl [TBL_DEPTH];
  logic [DB_W-1:0] dbQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
    end else if (tblWrEn) begin
      tbl[tblWrAddr] <= tblWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dbQ <= '0;
    else if (strobes.lookup) dbQ <= tbl[rdAddr];
  end

  assign levelFix = levelQ;
  assign levelDb  = dbQ;
endmodule

// File: rtl/agc_level_log.sv
module agc_level_log
  import agcdet_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int DET_W  = 10,
  parameter int DECIM  = 8,
  parameter int STAGES = 2,
  parameter int MANT_W = 2,
  parameter int DB_W   = 8,
  localparam int LVL_W  = DET_W - 1,
  localparam int ADDR_W = $clog2(LVL_W - MANT_W + 1) + MANT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   sampleIn,
  input  logic              tblWrEn,
  input  logic [ADDR_W-1:0] tblWrAddr,
  input  logic [DB_W-1:0]   tblWrData,
  output logic [LVL_W-1:0]  levelFix,
  output logic [DB_W-1:0]   levelDb,
  output logic              levelValid
);
  agcStrobes_t strobes;

  agcdet_ctrl #(
    .DECIM(DECIM)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .validOut(levelValid)
  );

  agcdet_datapath #(
    .IN_W  (IN_W),
    .DET_W (DET_W),
    .DECIM (DECIM),
    .STAGES(STAGES),
    .MANT_W(MANT_W),
    .DB_W  (DB_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sampleIn (sampleIn),
    .tblWrEn  (tblWrEn),
    .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData),
    .levelFix (levelFix),
    .levelDb  (levelDb)
  );
endmodule

// File: rtl/agcdet_chk.sv
module agcdet_chk #(
  parameter int IN_W  = 14,
  parameter int DET_W = 10,
  parameter int DECIM = 8,
  parameter int LVL_W = 9,
  parameter int DB_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [IN_W-1:0]  sampleIn,
  input logic [LVL_W-1:0] levelFix,
  input logic [DB_W-1:0]  levelDb,
  input logic             levelValid
);
  localparam int ZERO_NEED = 2 * DECIM + 4;

  logic [15:0] gap;
  logic        seenValid;
  logic [15:0] zeroRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap       <= '0;
      seenValid <= 1'b0;
      zeroRun   <= '0;
    end else begin
      gap       <= levelValid ? '0 : gap + 16'd1;
      seenValid <= seenValid | levelValid;
      if (sampleIn[IN_W-1 -: DET_W] != '0) zeroRun <= '0;
      else if (zeroRun != 16'hFFFF)         zeroRun <= zeroRun + 16'd1;
    end
  end

  AST_VALID_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (levelValid && seenValid) |-> (gap == 16'(DECIM - 1))) else $error("period");  // R4

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    levelValid |=> !levelValid) else $error("pulse width");  // R4

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !levelValid |-> $stable(levelDb)) else $error("db moved");  // R8

  AST_FIX_LEADS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelFix) |=> levelValid) else $error("fix moved");  // R8

  AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (levelValid && (zeroRun >= 16'(ZERO_NEED))) |-> (levelFix == '0)) else $error("zero");  // R5
endmodule

bind agc_level_log agcdet_chk #(
  .IN_W (IN_W),
  .DET_W(DET_W),
  .DECIM(DECIM),
  .LVL_W(LVL_W),
  .DB_W (DB_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleIn  (sampleIn),
  .levelFix  (levelFix),
  .levelDb   (levelDb),
  .levelValid(levelValid)
);

// File: tb/test_agc_level_log.sv
module test_agc_level_log;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] sampleIn = '0;
  logic        tblWrEn = 1'b0;
  logic [4:0]  tblWrAddr = '0;
  logic [7:0]  tblWrData = '0;
  logic [8:0]  levelFix;
  logic [7:0]  levelDb;
  logic        levelValid;

  agc_level_log i_agc_level_log (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .levelFix(levelFix), .levelDb(levelDb), .levelValid(levelValid)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int edges   = 0;
  int lastValid = -1;
  int hist [8192];
  logic [7:0] modelTbl [32];
  bit   pendWe = 1'b0;
  logic [4:0] pendA;
  logic [7:0] pendD;
  string curReq = "R5";

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, what, act, exp, edges);
    end
  endtask

  function automatic int absModel(input logic [13:0] s);
    int x;
    x = int'($signed(s[13:4]));
    if (x == -512) return 511;
    return (x < 0) ? -x : x;
  endfunction

  function automatic int expLevel(input int v);
    int acc = 0;
    for (int k = 1; k <= 15; k++) begin
      int idx = v - 3 - k;
      int w = 8 - ((k > 8) ? k - 8 : 8 - k);
      if (idx >= 1) acc += w * hist[idx];
    end
    return acc / 64;
  endfunction

  function automatic int expAddr(input int lvl);
    int p = -1;
    if (lvl < 4) return lvl;
    for (int i = 0; i < 9; i++) if ((lvl >> i) & 1) p = i;
    return ((p - 1) << 2) | ((lvl >> (p - 2)) & 3);
  endfunction

  task automatic monitor();
    if (levelValid) begin
      int ef = expLevel(edges);
      check(curReq, "levelFix", int'(levelFix), ef);
      check("R7", "levelDb", int'(levelDb), int'(modelTbl[expAddr(ef)]));
      if (lastValid < 0) check("R4", "first pulse edge", edges, 9);
      else               check("R4", "pulse spacing", edges - lastValid, 8);
      lastValid = edges;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic [13:0] s, input bit we, input logic [4:0] wa, input logic [7:0] wd);
    if (pendWe) modelTbl[pendA] = pendD;
    pendWe = we; pendA = wa; pendD = wd;
    sampleIn  = s;
    tblWrEn   = we;
    tblWrAddr = wa;
    tblWrData = wd;
    hist[edges + 1] = absModel(s);
    @(posedge clk);
    edges++;
    @(negedge clk);
    monitor();
  endtask

  task automatic run(input logic [13:0] s, input int n);
    for (int i = 0; i < n; i++) step(s, 1'b0, '0, '0);
  endtask

  initial begin
    automatic int seedInit = $urandom(32'h5EED_0042);
    seedInit = 0;
    for (int i = 0; i < 32; i++) modelTbl[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "levelValid in reset", int'(levelValid), 0);
    check("R1", "levelFix in reset", int'(levelFix), 0);
    check("R1", "levelDb in reset", int'(levelDb), 0);
    rstN = 1'b1;
    check("R1", "levelValid after release", int'(levelValid), 0);

    // Unprogrammed table reads zero (R1)
    curReq = "R1";
    run(14'(100 << 4), 40);

    // Program the log table
    for (int i = 0; i < 32; i++) step(14'(100 << 4), 1'b1, 5'(i), 8'((i * 7 + 3) & 255));

    // Steady magnitudes across the exponent ranges (R5, R6)
    curReq = "R5";
    foreach (hist[i]) if (i > edges) hist[i] = 0;
    run(14'(0), 40);
    curReq = "R6"; run(14'(3 << 4), 40);
    curReq = "R6"; run(14'(5 << 4), 40);
    curReq = "R5"; run(14'(100 << 4), 40);
    curReq = "R6"; run(14'(511 << 4), 40);
    check("R5", "settled 511", int'(levelFix), 511);
    curReq = "R3"; run(14'((-300) <<< 4), 40);
    check("R3", "settled -300", int'(levelFix), 300);
    curReq = "R3"; run({10'b10_0000_0000, 4'b0}, 40);
    check("R3", "settled -512 saturates", int'(levelFix), 511);

    // Low bits ignored (R2)
    curReq = "R2";
    for (int i = 0; i < 48; i++) step({10'd37, 4'($urandom)}, 1'b0, '0, '0);
    check("R2", "low bits ignored", int'(levelFix), 37);

    // Random samples at several scales (R5)
    curReq = "R5";
    for (int b = 0; b < 30; b++) begin
      int shiftAmt = int'($urandom % 9);
      for (int i = 0; i < 64; i++) begin
        logic [9:0] v = 10'($signed(10'($urandom)) >>> shiftAmt);
        step({v, 4'($urandom)}, 1'b0, '0, '0);
      end
    end

    // Rewrite table entries while running (R7)
    curReq = "R7";
    for (int i = 0; i < 32; i++) begin
      logic [9:0] v = 10'($urandom);
      step({v, 4'b0}, 1'b1, 5'($urandom), 8'($urandom));
      run({v, 4'b0}, int'($urandom % 5));
    end
    for (int i = 0; i < 200; i++) step({10'($urandom), 4'b0}, 1'b0, '0, '0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule